// File: doc/BRIEF.md
# DisplayPort Link Configuration Selector

This block chooses the per-lane link rate and the lane count for a DisplayPort transmitter, given the total data rate a video mode needs. It starts from the widest link allowed and trims it. First it halves the lane count while half as many lanes would still carry more than the need. Then, with that lane count fixed, it drops to a lower rate while the lower rate would still carry more than the need. The result is registered together with the source-side control words and the two configuration bytes destined for the sink.

The host pulses `start` to begin a search. It pulses `retry` after each failed training attempt. Each retry moves one step down a fixed rate list (270000, then 162000 kB/s per lane) and repeats the trimming. When the list runs out, the block raises `exhausted`. A `done` strobe marks every update. Rates and the data-rate requirement share one unit: kB/s, with the data rate taken over all lanes together.

Top module: `dp_link_select`

## Requirements
- R1: After reset, every output is zero: rate, lanes, both control words, both sink bytes, `exhausted` and `done`.
- R2: On `start`, the search begins at 270000, or at 162000 when `low_only` is 1. `start` also clears `exhausted`.
- R3: Starting from `max_lanes` (1, 2 or 4), the lane count is halved for as long as (lanes/2) times the starting rate is greater than `req_rate`.
- R4: With the lane count fixed, the rate moves to the next lower list entry for as long as that entry times the lane count is greater than `req_rate`. The list ends with 0, and 0 is never chosen.
- R5: On `retry` without `start`, the search begins at the list entry just below the rate currently selected. It repeats R3 and R4 using the present input values.
- R6: When a retry would begin past 162000, `exhausted` becomes 1 and the rate, lanes, words and bytes hold their last values. Further retries keep it at 1.
- R7: `clk_word` is 32'h0004_0000 when the selected rate is 270000 and 0 otherwise. It never has a bit set outside 32'h000C_0000.
- R8: `ctrl_word` holds ((1<<lanes)-1) starting at bit 16, plus bit 14 (32'h4000) when `enh_en` was 1 at the request. It never has a bit set outside 32'h001F_4000.
- R9: `sink_bw` is 8'h0A for 270000 and 8'h06 for 162000. `sink_lanes` holds the lane count in bits 4:0 and `enh_en` in bit 7.
- R10: `done` is 1 in the cycle after any cycle in which `start` or `retry` is 1, and 0 otherwise. When both are 1 in the same cycle, `start` takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search |
| retry | input | 1 | Last training failed; step down one rate |
| req_rate | input | 32 | Required data rate over all lanes, in kB/s |
| max_lanes | input | 3 | Largest usable lane count (1, 2 or 4) |
| low_only | input | 1 | Sink supports only the lower rate |
| enh_en | input | 1 | Enhanced framing requested |
| rate | output | 20 | Selected per-lane rate in kB/s |
| lanes | output | 3 | Selected lane count |
| clk_word | output | 32 | Rate clock-select word |
| ctrl_word | output | 32 | Lane-enable / framing control word |
| sink_bw | output | 8 | Sink link-rate byte |
| sink_lanes | output | 8 | Sink lane-count byte |
| exhausted | output | 1 | No lower rate remains |
| done | output | 1 | One-cycle strobe after each request |

## Verification
The bench builds the block with its default rates, 270000 and 162000 kB/s. These two rates make a complete descent reachable in two retries, so the exhausted state and its hold behaviour are reached quickly. The data-rate values used sit just above and just below the products of rate and lane count. These values drive the lane halving through zero, one and two steps, and drive the rate reduction on and off, for lane limits of 1, 2 and 4.

// File: rtl/dp_link_select.sv
module dp_link_select #(
  parameter int RATE_HI = 270000,
  parameter int RATE_LO = 162000,
  parameter int RW      = 20,
  parameter int DW      = 32,
  parameter int LW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          retry,
  input  logic [DW-1:0] req_rate,
  input  logic [LW-1:0] max_lanes,
  input  logic          low_only,
  input  logic          enh_en,
  output logic [RW-1:0] rate,
  output logic [LW-1:0] lanes,
  output logic [31:0]   clk_word,
  output logic [31:0]   ctrl_word,
  output logic [7:0]    sink_bw,
  output logic [7:0]    sink_lanes,
  output logic          exhausted,
  output logic          done
);
  localparam int NSTEP = LW - 1;
  localparam logic [31:0] CLK_MASK  = 32'h000C_0000;
  localparam logic [31:0] CTRL_MASK = 32'h001F_4000;

  function automatic logic [DW-1:0] rate_at(logic [1:0] i);
    case (i)
      2'd0:    rate_at = DW'(RATE_HI);
      2'd1:    rate_at = DW'(RATE_LO);
      default: rate_at = '0;
    endcase
  endfunction

  logic [1:0]    idx_q, base, sel;
  logic [DW-1:0] ln;
  logic          req;

  assign req  = start | retry;
  assign base = start ? {1'b0, low_only} : ((idx_q == 2'd2) ? 2'd2 : idx_q + 2'd1);

  always_comb begin
    ln = DW'(max_lanes);
    for (int k = 0; k < NSTEP; k++)
      if ((ln >> 1) * rate_at(base) > req_rate) ln = ln >> 1;
    sel = base;
    for (int k = 0; k < 2; k++)
      if (sel < 2'd2 && rate_at(sel + 2'd1) * ln > req_rate) sel = sel + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= '0;
      rate       <= '0;
      lanes      <= '0;
      clk_word   <= '0;
      ctrl_word  <= '0;
      sink_bw    <= '0;
      sink_lanes <= '0;
      exhausted  <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= req;
      if (req) begin
        if (base == 2'd2) begin
          idx_q     <= 2'd2;
          exhausted <= 1'b1;
        end else begin
          idx_q      <= sel;
          exhausted  <= 1'b0;
          rate       <= RW'(rate_at(sel));
          lanes      <= LW'(ln);
          clk_word   <= (sel == 2'd0) ? 32'h0004_0000 : 32'h0;
          ctrl_word  <= ((((32'd1 << ln[4:0]) - 32'd1) << 16) & 32'h001F_0000) |
                        (enh_en ? 32'h0000_4000 : 32'h0);
          sink_bw    <= (sel == 2'd0) ? 8'h0A : 8'h06;
          sink_lanes <= {enh_en, 2'b00, 5'(ln)};
        end
      end
    end
  end

  AST_CLK_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_word & ~CLK_MASK) == 32'h0); // R7
  AST_CTRL_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word & ~CTRL_MASK) == 32'h0); // R8
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start || retry) |=> done); // R10
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start || retry) |=> !done); // R10
  AST_LANES_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lanes)); // R3
  AST_EXH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exhausted && !start) |=> exhausted && $stable(rate) && $stable(lanes)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start || retry) |=> $stable(rate) && $stable(ctrl_word)); // R5
endmodule

// File: tb/dp_link_select_test.sv
module dp_link_select_test;
  localparam int PERIOD = 10;
  localparam int HI = 270000, LO = 162000;

  logic        clk = 0, rst_n = 0, start = 0, retry = 0, low_only = 0, enh_en = 0;
  logic [31:0] req_rate = 0;
  logic [2:0]  max_lanes = 3'd4;
  logic [19:0] rate;
  logic [2:0]  lanes;
  logic [31:0] clk_word, ctrl_word;
  logic [7:0]  sink_bw, sink_lanes;
  logic        exhausted, done;

  dp_link_select uut (.clk(clk), .rst_n(rst_n), .start(start), .retry(retry),
    .req_rate(req_rate), .max_lanes(max_lanes), .low_only(low_only), .enh_en(enh_en),
    .rate(rate), .lanes(lanes), .clk_word(clk_word), .ctrl_word(ctrl_word),
    .sink_bw(sink_bw), .sink_lanes(sink_lanes), .exhausted(exhausted), .done(done));

  always #(PERIOD/2) clk = ~clk;

  integer n_cmp = 0, n_bad = 0;
  string  phase = "R1 reset";
  integer m_idx = 0, m_rate = 0, m_lanes = 0, m_clk = 0, m_ctrl = 0, m_bw = 0, m_sl = 0;
  integer m_exh = 0, m_done = 0;

  function automatic integer rl(integer i);
    return (i == 0) ? HI : (i == 1) ? LO : 0;
  endfunction

  always @(posedge clk) begin
    integer b, l, s;
    if (!rst_n) begin
      m_idx = 0; m_rate = 0; m_lanes = 0; m_clk = 0; m_ctrl = 0;
      m_bw = 0; m_sl = 0; m_exh = 0; m_done = 0;
    end else begin
      m_done = (start || retry) ? 1 : 0;
      if (start || retry) begin
        if (start) b = low_only ? 1 : 0;
        else b = (m_idx >= 2) ? 2 : m_idx + 1;
        if (b == 2) begin
          m_idx = 2; m_exh = 1;
        end else begin
          l = max_lanes;
          while ((l / 2) * rl(b) > req_rate) l = l / 2;
          s = b;
          while (rl(s + 1) * l > req_rate) s = s + 1;
          m_idx = s; m_exh = 0; m_rate = rl(s); m_lanes = l;
          m_clk  = (s == 0) ? 32'h40000 : 0;
          m_ctrl = (((1 << l) - 1) << 16) + (enh_en ? 32'h4000 : 0);
          m_bw   = (s == 0) ? 8'h0A : 8'h06;
          m_sl   = l + (enh_en ? 128 : 0);
        end
      end
    end
  end

  task automatic cmp(string tag, integer act, integer exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("R4 rate", rate, m_rate);
    cmp("R3 lanes", lanes, m_lanes);
    cmp("R7 clk_word", clk_word, m_clk);
    cmp("R8 ctrl_word", ctrl_word, m_ctrl);
    cmp("R9 sink_bw", sink_bw, m_bw);
    cmp("R9 sink_lanes", sink_lanes, m_sl);
    cmp("R6 exhausted", exhausted, m_exh);
    cmp("R10 done", done, m_done);
  end

  task automatic pulse(input logic s, input logic r);
    @(negedge clk); #1; start = s; retry = r;
    @(negedge clk); #1; start = 0; retry = 0;
    @(negedge clk);
  endtask

  task automatic go(input integer rq, input integer ml, input logic lo, input logic en);
    @(negedge clk); #1; req_rate = rq; max_lanes = 3'(ml); low_only = lo; enh_en = en;
    pulse(1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    phase = "R2 full rate start";      go(1000000, 4, 0, 0);
    phase = "R5 retry to low rate";    pulse(0, 1);
    phase = "R6 exhaust";              pulse(0, 1);
    phase = "R6 retry while exhausted"; pulse(0, 1);
    phase = "R3 halve once enh";       go(500000, 4, 0, 1);
    phase = "R2 low_only";             go(300000, 4, 1, 0);
    phase = "R4 halve twice then drop"; go(100000, 4, 0, 1);
    phase = "R4 zero need";            go(0, 4, 0, 0);
    phase = "R3 two lane limit";       go(2000000, 2, 0, 0);
    phase = "R3 one lane limit";       go(2000000, 1, 0, 1);
    phase = "R5 retry after drop";     go(600000, 4, 0, 0); pulse(0, 1);
    phase = "R10 start beats retry";   @(negedge clk); #1 req_rate = 540000; pulse(1, 1);
    phase = "R4 boundary";
    for (int i = 0; i < 8; i++) begin
      integer v [8] = '{540000, 540001, 324000, 324001, 648000, 648001, 270000, 161999};
      go(v[i], 4, 0, i[0]);
      pulse(0, 1);
      pulse(0, 1);
    end
    phase = "R1 reset again";
    @(negedge clk); #1 rst_n = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule